// File: doc/BRIEF.md
# SD Command-Sequence Completion Flags

This block keeps two sticky status flags for an SD host controller: a response-end flag and an access-end flag. It sits beside the command and data sequencers and watches one-cycle event strobes from them: responses, busy releases, CRC status tokens, buffer reads, automatic stop-command responses, CMD52 responses, errors and timeouts. From these strobes it decides when a command sequence, or a whole data transfer, has truly finished.

The response-end flag follows the command line. It sets on a response, or when a command with no response is issued. For a busy-signalling (R1b) response it sets only when busy ends. The access-end flag follows the data transfer that `xfer_start` opens. It knows the direction, single or multi-block, whether an automatic CMD12 closes the transfer, and how many blocks remain. It also handles a software stop request and an I/O abort issued through CMD52. A communication error or timeout sets both flags and ends the transfer. Software reads both flags at `reg_rdata` and clears each one by writing zero to its bit.

Top module: `sd_done_flags`

## Requirements
- R1: The response-end flag (bit 0) sets on a response strobe without the R1b qualifier, or on a no-response command strobe, and is visible one clock later.
- R2: A response strobe with the R1b qualifier does not set response-end; the next busy-release strobe does.
- R3: While a multi-block transfer is open and `c52_busy_en` is 1, a CMD52 response strobe sets response-end; with `c52_busy_en` at 0 it does not.
- R4: An error or timeout strobe sets both flags and closes the open transfer, so later data strobes do not set access-end again.
- R5: In a write transfer, access-end (bit 1) sets on the busy release that follows a CRC status token. In a multi-block write it does so only for the last of `xfer_blocks` blocks.
- R6: In a read transfer, access-end sets on the buffer-read-done strobe of the only block (single) or of the last of `xfer_blocks` blocks (multi).
- R7: In a multi-block transfer with automatic stop, reads set access-end only once both the last buffer read and the stop-command response have been seen, in either order. Writes set it on the busy release after the stop-command response that follows the last block.
- R8: A stop request during a multi-block transfer with automatic stop makes access-end wait for the stop-command response (reads) or that response followed by busy release (writes), whatever the block count.
- R9: An I/O abort request during a multi-block transfer makes access-end set on the next CMD52 response strobe.
- R10: A register write clears each flag whose `reg_wdata` bit is 0. A bit written as 1 leaves its flag unchanged. Flags otherwise hold their value.
- R11: When a set event and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R12: After reset both flags read 0.
- R13: With no transfer open, data strobes (buffer read, CRC token, busy release, stop response) never set access-end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Opens a data transfer with the context below |
| xfer_write | input | 1 | 1 = write transfer, 0 = read transfer |
| xfer_multi | input | 1 | 1 = multi-block transfer |
| xfer_auto_stop | input | 1 | 1 = automatic CMD12 closes the multi-block transfer |
| xfer_blocks | input | BLK_W | Block count of a multi-block transfer (at least 1) |
| ev_rsp_rcvd | input | 1 | Command response received |
| ev_rsp_r1b | input | 1 | Qualifies ev_rsp_rcvd as a busy-signalling response |
| ev_norsp_cmd | input | 1 | A command without response was issued |
| ev_busy_rel | input | 1 | Data line busy released |
| ev_crc_tok | input | 1 | CRC status token received for a written block |
| ev_buf_rd_done | input | 1 | Software finished reading one block from the buffer |
| ev_stop_rsp | input | 1 | Response to the automatic stop command received |
| ev_c52_rsp | input | 1 | CMD52 response received |
| c52_busy_en | input | 1 | Mode: CMD52 may be issued during a multi-block transfer |
| sw_stop_req | input | 1 | Software stop request |
| io_abort_req | input | 1 | I/O abort request through CMD52 |
| ev_err | input | 1 | Communication error aborted the sequence |
| ev_tmo | input | 1 | Timeout aborted the sequence |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 2 | Write data, bit 0 response-end, bit 1 access-end |
| reg_rdata | output | 2 | Flags, bit 0 response-end, bit 1 access-end |

## Verification
Every flag result is due exactly one clock after its strobe, because each set condition is decoded from the strobe and the registered context in the same cycle and lands in the flag register at the next edge. The bench drives a strobe on a falling edge, drops it on the following falling edge, and reads `reg_rdata` at that moment, one rising edge later. A transfer that needs several strobes is checked after each one: access-end must still be 0 before the completing strobe and 1 right after it. Block counts, ordering, idle gaps and interleaved clears come from a seeded random stream.

// File: rtl/sdf_pkg.sv
// Package: shared types of the SD completion-flag unit.
// Assumes: nothing beyond IEEE 1800-2017.
package sdf_pkg;

    // Flag positions inside the status word; software decodes these.
    localparam int unsigned FLAG_RSP = 0;
    localparam int unsigned FLAG_ACC = 1;
    localparam int unsigned NFLAGS   = 2;

    // Early-termination kind of the open transfer.
    typedef enum logic [1:0] {
        TERM_NONE = 2'd0,
        TERM_STOP = 2'd1,
        TERM_IOAB = 2'd2
    } term_e;

    // Strobes from the sequencers, bundled for internal routing.
    typedef struct packed {
        logic rsp_rcvd;
        logic rsp_r1b;
        logic norsp_cmd;
        logic busy_rel;
        logic crc_tok;
        logic buf_rd_done;
        logic stop_rsp;
        logic c52_rsp;
        logic sw_stop;
        logic io_abort;
        logic kill;
    } sdf_ev_t;

endpackage

// File: rtl/sdf_sticky_flag.sv
// Module: one software-visible sticky flag.
// Sets on set_i; clears when a register write carries 0 for this bit.
// Assumes: set has priority over clear in the same cycle.
module sdf_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Hold, set or clear the flag; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sdf_rsp_track.sv
// Module: decides when the command sequence has ended (response-end).
// Tracks a pending busy-signalling response until busy is released.
// Assumes: strobes are one cycle wide; kill = error or timeout.
module sdf_rsp_track
    import sdf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sdf_ev_t ev_i,
    input  logic    c52_busy_en_i,
    input  logic    multi_open_i,
    output logic    rsp_set_o
);
    logic r1b_wait_q;
    logic r1b_wait_d;
    logic plain_rsp;
    logic busy_done;
    logic c52_hit;

    // Classify the strobes that end a command sequence.
    always_comb begin
        plain_rsp = ev_i.rsp_rcvd && !ev_i.rsp_r1b;
        busy_done = ev_i.busy_rel && r1b_wait_q;
        c52_hit   = ev_i.c52_rsp && c52_busy_en_i && multi_open_i;
        rsp_set_o = ev_i.kill || plain_rsp || ev_i.norsp_cmd
                  || busy_done || c52_hit;
    end

    // Next value of the pending busy-signalling response marker.
    always_comb begin
        r1b_wait_d = r1b_wait_q;
        if (ev_i.kill) begin
            r1b_wait_d = 1'b0;
        end else if (ev_i.rsp_rcvd && ev_i.rsp_r1b) begin
            r1b_wait_d = 1'b1;
        end else if (busy_done) begin
            r1b_wait_d = 1'b0;
        end
    end

    // Register the pending marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1b_wait_q <= 1'b0;
        end else begin
            r1b_wait_q <= r1b_wait_d;
        end
    end
endmodule

// File: rtl/sdf_xfer_track.sv
// Module: follows one data transfer and decides when it has ended
// (access-end). Keeps direction, block mode, automatic-stop mode, the
// remaining block count and any stop or I/O-abort request.
// Assumes: xfer_start opens a transfer and wins over other strobes in
// the same cycle, except kill; a multi-block count is at least 1.
module sdf_xfer_track
    import sdf_pkg::*;
#(
    parameter int unsigned BLK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             write_i,
    input  logic             multi_i,
    input  logic             auto_i,
    input  logic [BLK_W-1:0] blocks_i,
    input  sdf_ev_t          ev_i,
    output logic             acc_set_o,
    output logic             open_o,
    output logic             multi_open_o
);
    localparam logic [BLK_W-1:0] ONE_BLK = BLK_W'(1);

    logic             open_q,    open_d;
    logic             wr_q,      wr_d;
    logic             multi_q,   multi_d;
    logic             auto_q,    auto_d;
    logic [BLK_W-1:0] remain_q,  remain_d;
    term_e            term_q,    term_d;
    logic             crc_q,     crc_d;
    logic             data_q,    data_d;
    logic             stop_q,    stop_d;
    logic             sbusy_q,   sbusy_d;

    logic is_last;
    logic auto_multi;
    logic finish;
    logic rd_last;
    logic wr_blk_done;

    // Decode context conditions shared by several branches.
    always_comb begin
        is_last     = !multi_q || (remain_q == ONE_BLK);
        auto_multi  = multi_q && auto_q;
        rd_last     = ev_i.buf_rd_done && is_last && !data_q;
        wr_blk_done = ev_i.busy_rel && crc_q;
    end

    // Next-state and completion decision of the open transfer.
    always_comb begin
        open_d   = open_q;
        wr_d     = wr_q;
        multi_d  = multi_q;
        auto_d   = auto_q;
        remain_d = remain_q;
        term_d   = term_q;
        crc_d    = crc_q;
        data_d   = data_q;
        stop_d   = stop_q;
        sbusy_d  = sbusy_q;
        finish   = 1'b0;

        if (ev_i.kill) begin
            open_d = 1'b0;
        end else if (start_i) begin
            open_d   = 1'b1;
            wr_d     = write_i;
            multi_d  = multi_i;
            auto_d   = auto_i;
            remain_d = multi_i ? blocks_i : ONE_BLK;
            term_d   = TERM_NONE;
            crc_d    = 1'b0;
            data_d   = 1'b0;
            stop_d   = 1'b0;
            sbusy_d  = 1'b0;
        end else if (open_q) begin
            unique case (term_q)
                TERM_IOAB: begin
                    finish = ev_i.c52_rsp;
                end
                TERM_STOP: begin
                    if (!wr_q) begin
                        finish = ev_i.stop_rsp;
                    end else begin
                        if (ev_i.stop_rsp) begin
                            sbusy_d = 1'b1;
                        end
                        finish = ev_i.busy_rel && sbusy_q;
                    end
                end
                default: begin
                    if (ev_i.sw_stop && auto_multi) begin
                        term_d  = TERM_STOP;
                        sbusy_d = 1'b0;
                    end else if (ev_i.io_abort && multi_q) begin
                        term_d = TERM_IOAB;
                    end else if (!wr_q) begin
                        // Read: count buffer reads, then maybe the stop response.
                        if (ev_i.buf_rd_done && !is_last) begin
                            remain_d = remain_q - ONE_BLK;
                        end
                        if (auto_multi) begin
                            if (rd_last) begin
                                data_d = 1'b1;
                            end
                            if (ev_i.stop_rsp) begin
                                stop_d = 1'b1;
                            end
                            finish = (data_q || rd_last)
                                  && (stop_q || ev_i.stop_rsp);
                        end else begin
                            finish = rd_last;
                        end
                    end else begin
                        // Write: token then busy per block, then maybe the stop.
                        if (ev_i.crc_tok) begin
                            crc_d = 1'b1;
                        end
                        if (wr_blk_done) begin
                            crc_d = 1'b0;
                            if (!is_last) begin
                                remain_d = remain_q - ONE_BLK;
                            end else if (auto_multi) begin
                                data_d = 1'b1;
                            end else begin
                                finish = 1'b1;
                            end
                        end
                        if (auto_multi && data_q) begin
                            if (ev_i.stop_rsp) begin
                                sbusy_d = 1'b1;
                            end
                            finish = ev_i.busy_rel && sbusy_q;
                        end
                    end
                end
            endcase
            if (finish) begin
                open_d = 1'b0;
            end
        end
        acc_set_o = ev_i.kill || finish;
    end

    // Register the transfer context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q   <= 1'b0;
            wr_q     <= 1'b0;
            multi_q  <= 1'b0;
            auto_q   <= 1'b0;
            remain_q <= '0;
            term_q   <= TERM_NONE;
            crc_q    <= 1'b0;
            data_q   <= 1'b0;
            stop_q   <= 1'b0;
            sbusy_q  <= 1'b0;
        end else begin
            open_q   <= open_d;
            wr_q     <= wr_d;
            multi_q  <= multi_d;
            auto_q   <= auto_d;
            remain_q <= remain_d;
            term_q   <= term_d;
            crc_q    <= crc_d;
            data_q   <= data_d;
            stop_q   <= stop_d;
            sbusy_q  <= sbusy_d;
        end
    end

    assign open_o       = open_q;
    assign multi_open_o = open_q && multi_q;
endmodule

// File: rtl/sd_done_flags.sv
// Module: top of the SD completion-flag unit. Bundles the sequencer
// strobes, runs the command and transfer trackers, and holds the two
// sticky flags that software reads and clears by writing zero.
// Assumes: all strobes are synchronous to clk and one cycle wide.
module sd_done_flags
    import sdf_pkg::*;
#(
    parameter int unsigned BLK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             xfer_write,
    input  logic             xfer_multi,
    input  logic             xfer_auto_stop,
    input  logic [BLK_W-1:0] xfer_blocks,
    input  logic             ev_rsp_rcvd,
    input  logic             ev_rsp_r1b,
    input  logic             ev_norsp_cmd,
    input  logic             ev_busy_rel,
    input  logic             ev_crc_tok,
    input  logic             ev_buf_rd_done,
    input  logic             ev_stop_rsp,
    input  logic             ev_c52_rsp,
    input  logic             c52_busy_en,
    input  logic             sw_stop_req,
    input  logic             io_abort_req,
    input  logic             ev_err,
    input  logic             ev_tmo,
    input  logic             reg_wr,
    input  logic [NFLAGS-1:0] reg_wdata,
    output logic [NFLAGS-1:0] reg_rdata
);
    sdf_ev_t           ev;
    logic              rsp_set;
    logic              acc_set;
    logic              xfer_open;
    logic              multi_open;
    logic [NFLAGS-1:0] set_vec;

    // Bundle the sequencer strobes.
    always_comb begin
        ev.rsp_rcvd    = ev_rsp_rcvd;
        ev.rsp_r1b     = ev_rsp_r1b;
        ev.norsp_cmd   = ev_norsp_cmd;
        ev.busy_rel    = ev_busy_rel;
        ev.crc_tok     = ev_crc_tok;
        ev.buf_rd_done = ev_buf_rd_done;
        ev.stop_rsp    = ev_stop_rsp;
        ev.c52_rsp     = ev_c52_rsp;
        ev.sw_stop     = sw_stop_req;
        ev.io_abort    = io_abort_req;
        ev.kill        = ev_err || ev_tmo;
    end

    sdf_rsp_track u_rsp (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_i          (ev),
        .c52_busy_en_i (c52_busy_en),
        .multi_open_i  (multi_open),
        .rsp_set_o     (rsp_set)
    );

    sdf_xfer_track #(.BLK_W(BLK_W)) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (xfer_start),
        .write_i      (xfer_write),
        .multi_i      (xfer_multi),
        .auto_i       (xfer_auto_stop),
        .blocks_i     (xfer_blocks),
        .ev_i         (ev),
        .acc_set_o    (acc_set),
        .open_o       (xfer_open),
        .multi_open_o (multi_open)
    );

    // Place each set request at its flag position.
    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_RSP] = rsp_set;
        set_vec[FLAG_ACC] = acc_set;
    end

    for (genvar gi = 0; gi < NFLAGS; gi++) begin : g_flag
        sdf_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[gi]),
            .clr_i  (reg_wr && !reg_wdata[gi]),
            .flag_o (reg_rdata[gi])
        );
    end
endmodule

// File: rtl/sd_done_flags_chk.sv
// Module: property checker for sd_done_flags, bound to every instance.
// Assumes: observes only top ports and tracker outputs.
module sd_done_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_rsp_rcvd,
    input logic       ev_rsp_r1b,
    input logic       ev_norsp_cmd,
    input logic       ev_err,
    input logic       ev_tmo,
    input logic       reg_wr,
    input logic [1:0] reg_wdata,
    input logic [1:0] reg_rdata,
    input logic       rsp_set,
    input logic       acc_set,
    input logic       xfer_open
);
    assert_rsp_plain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rsp_rcvd && !ev_rsp_r1b) || ev_norsp_cmd |=> reg_rdata[0]);

    assert_abort_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err || ev_tmo) |=> (reg_rdata == 2'b11));

    assert_clear_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[0] && !rsp_set) |=> !reg_rdata[0]);

    assert_clear_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[1] && !acc_set) |=> !reg_rdata[1]);

    assert_hold_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && !(reg_wr && !reg_wdata[1])) |=> reg_rdata[1]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_set && reg_wr && !reg_wdata[1]) |=> reg_rdata[1]);

    assert_idle_no_acc_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_open && !ev_err && !ev_tmo) |-> !acc_set);
endmodule

bind sd_done_flags sd_done_flags_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_rsp_rcvd  (ev_rsp_rcvd),
    .ev_rsp_r1b   (ev_rsp_r1b),
    .ev_norsp_cmd (ev_norsp_cmd),
    .ev_err       (ev_err),
    .ev_tmo       (ev_tmo),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .rsp_set      (rsp_set),
    .acc_set      (acc_set),
    .xfer_open    (xfer_open)
);

// File: tb/sd_done_flags_test.sv
// Bench: directed corners plus seeded random transfers for sd_done_flags.
module sd_done_flags_test;
    localparam int BLK_W = 16;
    // Strobe selector bits used by fire().
    localparam int E_RSP = 0,  E_R1B = 1,  E_NORSP = 2, E_BUSY = 3;
    localparam int E_CRC = 4,  E_BUF = 5,  E_STOP  = 6, E_C52  = 7;
    localparam int E_SWS = 8,  E_IOA = 9,  E_ERR   = 10, E_TMO = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start = 0, xfer_write = 0, xfer_multi = 0, xfer_auto_stop = 0;
    logic [BLK_W-1:0] xfer_blocks = '0;
    logic ev_rsp_rcvd = 0, ev_rsp_r1b = 0, ev_norsp_cmd = 0, ev_busy_rel = 0;
    logic ev_crc_tok = 0, ev_buf_rd_done = 0, ev_stop_rsp = 0, ev_c52_rsp = 0;
    logic c52_busy_en = 0, sw_stop_req = 0, io_abort_req = 0;
    logic ev_err = 0, ev_tmo = 0, reg_wr = 0;
    logic [1:0] reg_wdata = 2'b11;
    logic [1:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sd_done_flags #(.BLK_W(BLK_W)) uut (.*);

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes (and an optional write) from a falling edge.
    task automatic fire(input logic [11:0] e, input logic wr = 0, input logic [1:0] wd = 2'b11);
        ev_rsp_rcvd = e[E_RSP]; ev_rsp_r1b = e[E_R1B]; ev_norsp_cmd = e[E_NORSP];
        ev_busy_rel = e[E_BUSY]; ev_crc_tok = e[E_CRC]; ev_buf_rd_done = e[E_BUF];
        ev_stop_rsp = e[E_STOP]; ev_c52_rsp = e[E_C52]; sw_stop_req = e[E_SWS];
        io_abort_req = e[E_IOA]; ev_err = e[E_ERR]; ev_tmo = e[E_TMO];
        reg_wr = wr; reg_wdata = wd;
        @(negedge clk);
        {ev_rsp_rcvd, ev_rsp_r1b, ev_norsp_cmd, ev_busy_rel, ev_crc_tok, ev_buf_rd_done} = '0;
        {ev_stop_rsp, ev_c52_rsp, sw_stop_req, io_abort_req, ev_err, ev_tmo} = '0;
        reg_wr = 0; reg_wdata = 2'b11;
    endtask

    function automatic logic [11:0] b(input int i);
        return 12'(1) << i;
    endfunction

    task automatic clear_all();
        fire('0, 1'b1, 2'b00);
    endtask

    task automatic start(input logic wr, input logic mb, input logic au, input int n);
        xfer_start = 1; xfer_write = wr; xfer_multi = mb; xfer_auto_stop = au;
        xfer_blocks = BLK_W'(n);
        @(negedge clk);
        xfer_start = 0;
    endtask

    task automatic gap();
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    // Expected access-end after a read transfer's buffer read number k.
    function automatic logic rd_done_exp(input int k, input int n, input logic mb, input logic au, input logic rsp_seen);
        if (!mb) return 1'b1;
        if (k < n) return 1'b0;
        return au ? rsp_seen : 1'b1;
    endfunction

    // Random read transfer; access-end checked after every strobe.
    task automatic rand_read();
        logic mb, au, early;
        int n;
        mb = 1'($urandom_range(0, 1)); au = mb & 1'($urandom_range(0, 1));
        n = mb ? $urandom_range(1, 6) : 1;
        early = au & 1'($urandom_range(0, 1));
        clear_all();
        start(1'b0, mb, au, n);
        if (early) begin
            fire(b(E_STOP));
            chk("R7 stop rsp before last read", reg_rdata & 2'b10, 2'b00);
        end
        for (int k = 1; k <= n; k++) begin
            gap();
            fire(b(E_BUF));
            chk(mb ? "R6/R7 multi read block" : "R6 single read",
                reg_rdata & 2'b10, {rd_done_exp(k, n, mb, au, early), 1'b0});
        end
        if (au && !early) begin
            gap();
            fire(b(E_STOP));
            chk("R7 stop rsp after last read", reg_rdata & 2'b10, 2'b10);
        end
    endtask

    // Random write transfer; access-end checked after every strobe.
    task automatic rand_write();
        logic mb, au;
        int n;
        mb = 1'($urandom_range(0, 1)); au = mb & 1'($urandom_range(0, 1));
        n = mb ? $urandom_range(1, 6) : 1;
        clear_all();
        start(1'b1, mb, au, n);
        for (int k = 1; k <= n; k++) begin
            gap();
            fire(b(E_CRC));
            chk("R5 token alone", reg_rdata & 2'b10, 2'b00);
            fire(b(E_BUSY));
            chk("R5 write block busy release", reg_rdata & 2'b10,
                {(k == n) && !au, 1'b0});
        end
        if (au) begin
            fire(b(E_STOP));
            chk("R7 write stop rsp", reg_rdata & 2'b10, 2'b00);
            gap();
            fire(b(E_BUSY));
            chk("R7 write stop busy release", reg_rdata & 2'b10, 2'b10);
        end
    endtask

    initial begin
        void'($urandom(32'h5D0C_0A11));
        repeat (3) @(negedge clk);
        chk("R12 reset", reg_rdata, 2'b00);
        rst_n = 1;
        @(negedge clk);
        chk("R12 after reset", reg_rdata, 2'b00);

        fire(b(E_RSP));
        chk("R1 plain response", reg_rdata, 2'b01);
        fire('0, 1'b1, 2'b11);
        chk("R10 write of one keeps flag", reg_rdata, 2'b01);
        fire('0, 1'b1, 2'b10);
        chk("R10 write of zero clears", reg_rdata, 2'b00);
        fire(b(E_NORSP));
        chk("R1 no-response command", reg_rdata, 2'b01);
        clear_all();

        fire(b(E_RSP) | b(E_R1B));
        chk("R2 R1b response alone", reg_rdata, 2'b00);
        fire(b(E_BUSY));
        chk("R2 busy release after R1b", reg_rdata, 2'b01);
        fire(b(E_RSP), 1'b1, 2'b00);
        chk("R11 set beats clear", reg_rdata, 2'b01);
        clear_all();

        fire(b(E_BUF) | b(E_CRC) | b(E_STOP));
        fire(b(E_BUSY));
        chk("R13 idle data strobes", reg_rdata, 2'b00);

        // CMD52 during a multi-block read, mode off then on.
        start(1'b0, 1'b1, 1'b0, 4);
        fire(b(E_C52));
        chk("R3 CMD52 with mode off", reg_rdata, 2'b00);
        c52_busy_en = 1;
        fire(b(E_C52));
        chk("R3 CMD52 with mode on", reg_rdata, 2'b01);
        c52_busy_en = 0;
        clear_all();
        fire(b(E_IOA));
        fire(b(E_BUF));
        chk("R9 read ignored during abort", reg_rdata, 2'b00);
        fire(b(E_C52));
        chk("R9 CMD52 response ends abort", reg_rdata, 2'b10);
        clear_all();

        // Stop request on long transfers.
        start(1'b0, 1'b1, 1'b1, 9);
        fire(b(E_BUF));
        fire(b(E_SWS));
        fire(b(E_STOP));
        chk("R8 read stop response", reg_rdata, 2'b10);
        clear_all();
        start(1'b1, 1'b1, 1'b1, 9);
        fire(b(E_SWS));
        fire(b(E_STOP));
        chk("R8 write stop rsp no busy yet", reg_rdata, 2'b00);
        fire(b(E_BUSY));
        chk("R8 write stop busy release", reg_rdata, 2'b10);
        clear_all();

        // Error and timeout end the transfer.
        start(1'b0, 1'b0, 1'b0, 1);
        fire(b(E_ERR));
        chk("R4 error sets both", reg_rdata, 2'b11);
        clear_all();
        fire(b(E_BUF));
        chk("R4 transfer closed after error", reg_rdata, 2'b00);
        start(1'b1, 1'b1, 1'b0, 3);
        fire(b(E_TMO), 1'b1, 2'b00);
        chk("R4 R11 timeout with clear", reg_rdata, 2'b11);
        clear_all();

        for (int i = 0; i < 60; i++) begin
            if ($urandom_range(0, 1) == 1) rand_read();
            else rand_write();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule